// File: doc/BRIEF.md
# Strided DMA Address Generator

This block produces the byte addresses for one DMA transfer, as a source/destination address pair and a beat length for each accepted handshake. A load pulse captures the start addresses, the total byte count, a maximum beat width and an extended-mode flag. It also captures, for each side independently, a stride enable, a run size and a run-to-run distance. Each beat is held on the outputs until a ready pulse accepts it.

A strided side moves a contiguous run of bytes and then jumps so that the next run begins a fixed distance after the start of the previous one. Striding takes effect only in extended mode. Otherwise both sides walk contiguously, exactly as a plain single transfer with the same start and count would. When the last beat is accepted the generator raises done and stays there until the next load.

Top module: `dma_stride_agen`

## Requirements
- R1: With extended mode set and a side's stride enable clear, that side's address for byte offset k of the transfer is start + k.
- R2: With extended mode clear, both stride enables are ignored and both sides address start + k.
- R3: A strided side (extended mode set, enable set, run size S nonzero, distance D) addresses start + (k div S)·D + (k mod S), independently of the other side.
- R4: A stride distance smaller than the run size is used as equal to the run size.
- R5: A stride enable with a run size of zero leaves that side contiguous.
- R6: Each beat length equals the minimum of the beat width, the bytes left in the current source run, the bytes left in the current destination run and the bytes left in the transfer; a beat width of zero counts as one.
- R7: While valid is high and ready is low, the address pair and beat length hold steady.
- R8: Done rises in the cycle after the last beat is accepted, and valid is low from that cycle.
- R9: Once done, ready pulses have no effect: done stays high and valid stays low until the next load.
- R10: A load with a byte count of zero gives no beats and raises done in the cycle after the load.
- R11: After reset, valid and done are low.
- R12: Addresses are 36 bits wide and wrap modulo 2^36; byte count and stride fields are 26 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture a new transfer setup and restart |
| ext_mode | input | 1 | Extended mode; stride enables act only when set |
| beat_width | input | 7 | Largest beat in bytes (0 treated as 1) |
| byte_count | input | 26 | Total bytes in the transfer |
| src_start | input | 36 | First source byte address |
| src_str_en | input | 1 | Source stride enable |
| src_run | input | 26 | Source run size in bytes |
| src_gap | input | 26 | Source distance between run starts |
| dst_start | input | 36 | First destination byte address |
| dst_str_en | input | 1 | Destination stride enable |
| dst_run | input | 26 | Destination run size in bytes |
| dst_gap | input | 26 | Destination distance between run starts |
| ready | input | 1 | Accepts the beat on the outputs |
| valid | output | 1 | A beat is on the outputs |
| src_addr | output | 36 | Source address of the current beat |
| dst_addr | output | 36 | Destination address of the current beat |
| beat_len | output | 7 | Byte length of the current beat |
| done | output | 1 | Transfer finished |

## Verification
The hardest case to reach is a beat cut short at once by a source run end, a destination run end and the transfer end, under stalled handshakes. The sweep crosses small run sizes on both sides (including zero and a distance below the size), several beat widths and byte counts, and every combination of the mode flag and the two enables. Ready is held low on every fourth cycle, so many beats are stalled at different points inside a run. The source start sits just below 2^36, so runs wrap through the top of the address space.

// File: rtl/agen_pkg.sv
package agen_pkg;
    localparam int ADDR_W = 36;
    localparam int CNT_W  = 26;
    localparam int BLEN_W = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [BLEN_W-1:0] blen_t;

    typedef struct packed {
        logic en;
        cnt_t run;
        cnt_t gap;
    } stride_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } agen_state_e;

    function automatic cnt_t cnt_min(input cnt_t a, input cnt_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/agen_side.sv
module agen_side
    import agen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic        ext_mode,
    input  addr_t       start_i,
    input  stride_cfg_t cfg_i,
    input  cnt_t        count_i,
    input  logic        adv_i,
    input  blen_t       len_i,
    output addr_t       addr_o,
    output cnt_t        run_left_o
);
    logic  strided_q;
    cnt_t  run_q;
    cnt_t  gap_q;
    addr_t base_q;
    addr_t addr_q;
    cnt_t  left_q;

    logic  use_stride;
    cnt_t  gap_eff;
    logic  run_end;

    assign use_stride = ext_mode && cfg_i.en && (cfg_i.run != '0);
    assign gap_eff    = (cfg_i.gap < cfg_i.run) ? cfg_i.run : cfg_i.gap;
    assign run_end    = strided_q && (left_q == cnt_t'(len_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            strided_q <= 1'b0;
            run_q     <= '0;
            gap_q     <= '0;
            base_q    <= '0;
            addr_q    <= '0;
            left_q    <= '0;
        end else if (load) begin
            strided_q <= use_stride;
            run_q     <= cfg_i.run;
            gap_q     <= gap_eff;
            base_q    <= start_i;
            addr_q    <= start_i;
            left_q    <= use_stride ? cfg_i.run : count_i;
        end else if (adv_i) begin
            if (run_end) begin
                base_q <= base_q + addr_t'(gap_q);
                addr_q <= base_q + addr_t'(gap_q);
                left_q <= run_q;
            end else begin
                addr_q <= addr_q + addr_t'(len_i);
                left_q <= left_q - cnt_t'(len_i);
            end
        end
    end

    assign addr_o     = addr_q;
    assign run_left_o = left_q;

    // R1 / R2 / R5: a contiguous side steps by exactly the accepted length
    a_r1_contig_step: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load && !strided_q) |=> (addr_o == $past(addr_o) + addr_t'($past(len_i))));

    // R3: a strided side never reports an empty or oversized run remainder
    a_r3_run_left_bounded: assert property (@(posedge clk) disable iff (rst)
        strided_q |-> (run_left_o != '0 && run_left_o <= run_q));
endmodule

// File: rtl/agen_beat.sv
module agen_beat
    import agen_pkg::*;
(
    input  blen_t width_i,
    input  cnt_t  src_left_i,
    input  cnt_t  dst_left_i,
    input  cnt_t  remain_i,
    output blen_t len_o
);
    cnt_t m;

    always_comb begin
        m     = cnt_min(cnt_min(cnt_t'(width_i), src_left_i),
                        cnt_min(dst_left_i, remain_i));
        len_o = blen_t'(m);
    end
endmodule

// File: rtl/dma_stride_agen.sv
module dma_stride_agen
    import agen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              ext_mode,
    input  logic [BLEN_W-1:0] beat_width,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [ADDR_W-1:0] src_start,
    input  logic              src_str_en,
    input  logic [CNT_W-1:0]  src_run,
    input  logic [CNT_W-1:0]  src_gap,
    input  logic [ADDR_W-1:0] dst_start,
    input  logic              dst_str_en,
    input  logic [CNT_W-1:0]  dst_run,
    input  logic [CNT_W-1:0]  dst_gap,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [BLEN_W-1:0] beat_len,
    output logic              done
);
    localparam int NSIDE = 2;

    agen_state_e state_q;
    cnt_t        rem_q;
    blen_t       bw_q;
    logic        adv;
    blen_t       len_w;

    stride_cfg_t cfg   [NSIDE];
    addr_t       start [NSIDE];
    addr_t       addr  [NSIDE];
    cnt_t        left  [NSIDE];

    assign cfg[0]   = '{en: src_str_en, run: src_run, gap: src_gap};
    assign cfg[1]   = '{en: dst_str_en, run: dst_run, gap: dst_gap};
    assign start[0] = src_start;
    assign start[1] = dst_start;

    assign valid = (state_q == ST_RUN);
    assign done  = (state_q == ST_FIN);
    assign adv   = valid && ready && !load;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        agen_side u_side (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .ext_mode   (ext_mode),
            .start_i    (start[s]),
            .cfg_i      (cfg[s]),
            .count_i    (byte_count),
            .adv_i      (adv),
            .len_i      (len_w),
            .addr_o     (addr[s]),
            .run_left_o (left[s])
        );
    end

    agen_beat u_beat (
        .width_i    (bw_q),
        .src_left_i (left[0]),
        .dst_left_i (left[1]),
        .remain_i   (rem_q),
        .len_o      (len_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            bw_q    <= '0;
        end else if (load) begin
            state_q <= (byte_count == '0) ? ST_FIN : ST_RUN;
            rem_q   <= byte_count;
            bw_q    <= (beat_width == '0) ? blen_t'(1) : beat_width;
        end else if (adv) begin
            rem_q <= rem_q - cnt_t'(len_w);
            if (rem_q == cnt_t'(len_w)) state_q <= ST_FIN;
        end
    end

    assign src_addr = addr[0];
    assign dst_addr = addr[1];
    assign beat_len = len_w;

    // R6: a live beat is nonempty and bounded by the width and the remainder
    a_r6_len_bounds: assert property (@(posedge clk) disable iff (rst)
        valid |-> (beat_len != '0 && beat_len <= bw_q && cnt_t'(beat_len) <= rem_q));

    // R7: a stalled beat holds
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !load) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(beat_len)));

    // R8: done follows acceptance of the final beat
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_t'(beat_len) == rem_q) |=> (done && !valid));

    // R9: done is sticky until a load
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> (done && !valid));
endmodule

// File: tb/sim_dma_stride_agen.sv
module sim_dma_stride_agen;
    import agen_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, load, ext_mode, ready;
    blen_t       beat_width;
    cnt_t        byte_count, src_run, src_gap, dst_run, dst_gap;
    addr_t       src_start, dst_start;
    logic        src_str_en, dst_str_en;
    logic        valid, done;
    addr_t       src_addr, dst_addr;
    blen_t       beat_len;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    dma_stride_agen u0 (
        .clk(clk), .rst(rst), .load(load), .ext_mode(ext_mode),
        .beat_width(beat_width), .byte_count(byte_count),
        .src_start(src_start), .src_str_en(src_str_en), .src_run(src_run), .src_gap(src_gap),
        .dst_start(dst_start), .dst_str_en(dst_str_en), .dst_run(dst_run), .dst_gap(dst_gap),
        .ready(ready), .valid(valid), .src_addr(src_addr), .dst_addr(dst_addr),
        .beat_len(beat_len), .done(done)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic addr_t model_addr(input addr_t st, input bit str, input int sz,
                                         input int ds, input int k);
        int d;
        if (!str) return st + addr_t'(k);
        d = (ds < sz) ? sz : ds;
        return st + addr_t'(k / sz) * addr_t'(d) + addr_t'(k % sz);
    endfunction

    function automatic string side_tag(input bit ext, input bit en, input int sz, input int ds);
        if (ext && en && sz != 0) return (ds < sz) ? "R4" : "R3";
        if (!ext && en) return "R2";
        if (en && sz == 0) return "R5";
        return "R1";
    endfunction

    task automatic run_case(input bit ext, input bit sen, input int ssz, input int sds,
                            input bit den, input int dsz, input int dds,
                            input int cnt, input int bw);
        int    k, bwe, elen, sl, dl;
        bit    sstr, dstr, prev_rdy;
        addr_t es, ed, prev_s, prev_d;
        blen_t prev_l;
        string st, dt;
        @(negedge clk);
        ext_mode = ext; beat_width = blen_t'(bw); byte_count = cnt_t'(cnt);
        src_str_en = sen; src_run = cnt_t'(ssz); src_gap = cnt_t'(sds);
        dst_str_en = den; dst_run = cnt_t'(dsz); dst_gap = cnt_t'(dds);
        load = 1'b1; ready = 1'b0;
        @(negedge clk);
        load = 1'b0;
        sstr = ext && sen && ssz != 0;
        dstr = ext && den && dsz != 0;
        bwe  = (bw == 0) ? 1 : bw;
        st   = side_tag(ext, sen, ssz, sds);
        dt   = side_tag(ext, den, dsz, dds);
        k = 0; prev_rdy = 1'b1; prev_s = '0; prev_d = '0; prev_l = '0;
        while (k < cnt) begin
            es = model_addr(src_start, sstr, ssz, sds, k);
            ed = model_addr(dst_start, dstr, dsz, dds, k);
            sl = sstr ? (ssz - k % ssz) : (cnt - k);
            dl = dstr ? (dsz - k % dsz) : (cnt - k);
            elen = bwe;
            if (sl < elen) elen = sl;
            if (dl < elen) elen = dl;
            if (cnt - k < elen) elen = cnt - k;
            chk("R6 valid", {63'd0, valid}, 64'd1);
            chk((es < src_start) ? "R12" : st, 64'(src_addr), 64'(es));
            chk(dt, 64'(dst_addr), 64'(ed));
            chk("R6", 64'(beat_len), 64'(elen));
            if (!prev_rdy) begin
                chk("R7 src", 64'(src_addr), 64'(prev_s));
                chk("R7 dst", 64'(dst_addr), 64'(prev_d));
                chk("R7 len", 64'(beat_len), 64'(prev_l));
            end
            prev_s = src_addr; prev_d = dst_addr; prev_l = beat_len;
            ready = ((cyc % 4) != 2);
            prev_rdy = ready;
            cyc++;
            if (ready) k += elen;
            @(negedge clk);
        end
        chk((cnt == 0) ? "R10 done" : "R8 done", {63'd0, done}, 64'd1);
        chk((cnt == 0) ? "R10 valid" : "R8 valid", {63'd0, valid}, 64'd0);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        chk("R9 done", {63'd0, done}, 64'd1);
        chk("R9 valid", {63'd0, valid}, 64'd0);
    endtask

    initial begin
        #1_900_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; load = 1'b0; ready = 1'b0; ext_mode = 1'b0;
        beat_width = '0; byte_count = '0;
        src_str_en = 1'b0; src_run = '0; src_gap = '0;
        dst_str_en = 1'b0; dst_run = '0; dst_gap = '0;
        src_start = 36'hF_FFFF_FFF8;   // R12: wraps through 2^36 during the sweep
        dst_start = 36'h0_0000_1000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 valid", {63'd0, valid}, 64'd0);
        chk("R11 done", {63'd0, done}, 64'd0);
        for (int bi = 0; bi < 4; bi++) begin
            for (int ssz = 0; ssz < 4; ssz++) begin
                for (int dsz = 0; dsz < 3; dsz++) begin
                    for (int ci = 0; ci < 4; ci++) begin
                        for (int ex = 0; ex < 2; ex++) begin
                            for (int en = 0; en < 4; en++) begin
                                int bw, cnt;
                                bw  = (bi == 0) ? 1 : (bi == 1) ? 3 : (bi == 2) ? 4 : 0;
                                cnt = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 7 : 13;
                                run_case(ex[0], en[0], ssz, (ssz == 2) ? 1 : 5,
                                         en[1], dsz, dsz + 2, cnt, bw);
                            end
                        end
                    end
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule